// File: doc/BRIEF.md
# Selectable Synchronous Serial Shifter

This block moves one byte at a time over a three-wire synchronous link (shift clock, serial out, serial in). A single shift register doubles as the transmit and receive buffer: software writes a byte to it, the block shifts that byte out while shifting the incoming line into the vacated end, and after the eighth clock the same register holds the received byte. A bit counter tracks position within the byte. When it wraps, the block drops its busy flag and raises a completion pulse.

A small mode register is written before a transfer. It chooses between full-duplex operation and receive-only operation, in which the serial output is left untouched. It also chooses whether bits travel most-significant or least-significant first, and where the shift clock comes from. There are three clock sources. The block can generate the shift clock itself from a divided system clock. It can follow an external clock pin, which it synchronises into the system clock domain. Or it can toggle its shift clock on each strobe from a companion timer. Data are sampled on rising shift-clock edges and launched on falling edges.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, busy and done_irq are 0, so and sck_out are 1, and the mode register and the buffer both read as 0.
- R2: A buffer write (reg_wr=1, reg_sel=1) while busy is 0 loads the buffer and sets busy from the next cycle. A buffer write while busy is 1 is ignored and leaves the buffer contents alone.
- R3: Outside receive-only mode, so carries the written byte one bit per shift clock. Mode bit 1 selects the order: 0 means bit 7 first, 1 means bit 0 first. The first bit appears on so right after the write, and so changes only on falling shift-clock edges after that.
- R4: si is sampled on every rising shift-clock edge and shifted into the buffer. After eight bits the buffer reads back the arriving byte, assembled with the same order rule as R3.
- R5: With mode bit 0 set (receive-only), so keeps its level for the whole transfer and the buffer is filled from si alone.
- R6: On the eighth rising shift-clock edge, busy clears and done_irq is 1 for exactly one cycle.
- R7: With mode bits [3:2]=00 (internal clock), sck_drive is 1 and sck_out idles high. sck_out gives exactly eight low pulses per transfer, each level lasting HALF_DIV system clocks, so busy stays high for 16*HALF_DIV cycles.
- R8: With mode bits [3:2]=01 (external clock), sck_in is synchronised and its edges drive the shifter. sck_drive is 0 and sck_out stays 1. Edges on sck_in while idle do nothing.
- R9: With mode bit 3 set (timer clock), each tmr_strobe pulse during a transfer toggles sck_out. Strobes while idle do nothing.
- R10: A mode write (reg_wr=1, reg_sel=0) while busy is ignored. A mode write while idle stores reg_wdata[3:0].
- R11: reg_rdata shows the mode in bits [3:0] with zeros above when reg_sel=0, and the buffer when reg_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mode register, 1 selects the buffer |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Generated shift clock (internal or timer source) |
| sck_drive | output | 1 | 1 when sck_out is the active clock source |
| tmr_strobe | input | 1 | Timer overflow strobe used as clock source |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a register write that lands in the middle of a transfer. The bench has to time the write against a running shift clock and then show through the read port that the write was refused. It starts an all-zero transfer with si held low, writes 0xFF to the buffer and a new mode a few cycles in, and reads both registers back at once and again after completion. The external-clock case is also hard to observe: each sck_in edge crosses a synchroniser before it acts. So the bench holds each level for several system clocks and samples so only after that settling window.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   localparam int MODE_W = 4;

   typedef enum logic [1:0] {
      CLK_INT  = 2'b00,
      CLK_EXT  = 2'b01,
      CLK_TMR  = 2'b10,
      CLK_TMRB = 2'b11
   } clk_src_e;

   typedef struct packed {
      clk_src_e src;
      logic     lsb_first;
      logic     rx_only;
   } mode_t;

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
   parameter int HALF_DIV    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  ssp_pkg::clk_src_e src,
   input  logic              sck_in,
   input  logic              tmr_strobe,
   output logic              rise_evt,
   output logic              fall_evt,
   output logic              sck_out,
   output logic              sck_drive
);
   import ssp_pkg::*;

   logic is_ext;
   logic is_tmr;
   logic tick;
   logic toggle;
   logic lvl_q;
   logic [SYNC_STAGES-1:0] sync_q;
   logic ext_now;
   logic ext_prev_q;

   assign is_ext = (src == CLK_EXT);
   assign is_tmr = src[1];

   // divider: half period of the internal shift clock
   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int DW = $clog2(HALF_DIV);
         localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_q <= '0;
            else if (!run)           div_q <= '0;
            else if (div_q == LAST)  div_q <= '0;
            else                     div_q <= div_q + 1'b1;
         end
         assign tick = run && (div_q == LAST);
      end
   endgenerate

   // external clock synchroniser, idles high
   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= sck_in;
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
         end
      end
   endgenerate

   assign ext_now = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_prev_q <= 1'b1;
      else        ext_prev_q <= ext_now;
   end

   // locally generated shift clock level
   assign toggle = run && !is_ext && (is_tmr ? tmr_strobe : tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q <= 1'b1;
      else if (toggle) lvl_q <= ~lvl_q;
   end

   always_comb begin
      if (is_ext) begin
         rise_evt = run &&  ext_now && !ext_prev_q;
         fall_evt = run && !ext_now &&  ext_prev_q;
      end else begin
         rise_evt = toggle && !lvl_q;
         fall_evt = toggle &&  lvl_q;
      end
   end

   assign sck_out   = is_ext ? 1'b1 : lvl_q;
   assign sck_drive = !is_ext;

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              rise_evt,
   input  logic              fall_evt,
   input  logic              lsb_first,
   input  logic              rx_only,
   input  logic              si,
   output logic [DATA_W-1:0] buf_q,
   output logic              so,
   output logic              wrap
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] shift_next;
   logic              load_bit;
   logic              cur_bit;

   always_comb begin
      if (lsb_first) begin
         shift_next = {si, buf_q[DATA_W-1:1]};
         load_bit   = load_data[0];
         cur_bit    = buf_q[0];
      end else begin
         shift_next = {buf_q[DATA_W-2:0], si};
         load_bit   = load_data[DATA_W-1];
         cur_bit    = buf_q[DATA_W-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         buf_q <= load_data;
         cnt_q <= '0;
      end else if (rise_evt) begin
         buf_q <= shift_next;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign wrap = rise_evt && (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                so <= 1'b1;
      else if (!rx_only) begin
         if (load)               so <= load_bit;
         else if (fall_evt)      so <= cur_bit;
      end
   end

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl #(
   parameter int DATA_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_sel,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               wrap,
   output ssp_pkg::mode_t     mode_q,
   output logic               busy,
   output logic               done_irq,
   output logic               load
);
   import ssp_pkg::*;

   logic mode_wr;

   assign mode_wr = reg_wr && !reg_sel && !busy;
   assign load    = reg_wr &&  reg_sel && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_wr) mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy <= 1'b0;
      else if (load) busy <= 1'b1;
      else if (wrap) busy <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_irq <= 1'b0;
      else        done_irq <= wrap;
   end

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
   parameter int DATA_W      = 8,
   parameter int HALF_DIV    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_drive,
   input  logic              tmr_strobe,
   input  logic              si,
   output logic              so,
   output logic              busy,
   output logic              done_irq
);
   import ssp_pkg::*;

   generate
      if (DATA_W < MODE_W || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two no smaller than the mode field");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   mode_t             mode_q;
   logic [MODE_W-1:0] mode_bits;
   logic              load;
   logic              wrap;
   logic              rise_evt;
   logic              fall_evt;
   logic [DATA_W-1:0] buf_q;

   assign mode_bits = mode_q;

   ssp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .wrap      (wrap),
      .mode_q    (mode_q),
      .busy      (busy),
      .done_irq  (done_irq),
      .load      (load)
   );

   ssp_clkgen #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (busy),
      .src        (mode_q.src),
      .sck_in     (sck_in),
      .tmr_strobe (tmr_strobe),
      .rise_evt   (rise_evt),
      .fall_evt   (fall_evt),
      .sck_out    (sck_out),
      .sck_drive  (sck_drive)
   );

   ssp_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (reg_wdata),
      .rise_evt  (rise_evt),
      .fall_evt  (fall_evt),
      .lsb_first (mode_q.lsb_first),
      .rx_only   (mode_q.rx_only),
      .si        (si),
      .buf_q     (buf_q),
      .so        (so),
      .wrap      (wrap)
   );

   assign reg_rdata = reg_sel ? buf_q : {{(DATA_W-MODE_W){1'b0}}, mode_bits};

endmodule

// File: rtl/sync_shift_port_chk.sv
module sync_shift_port_chk #(
   parameter int DATA_W = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic       reg_sel,
   input logic       busy,
   input logic       done_irq,
   input logic       so,
   input logic       sck_out,
   input logic [3:0] mode_bits,
   input logic       rise_evt
);
   localparam int RW = $clog2(DATA_W) + 1;
   logic [RW-1:0] rise_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rise_cnt <= '0;
      else if (busy) rise_cnt <= rise_cnt + RW'(rise_evt);
      else           rise_cnt <= '0;
   end

   a_r2_busy_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && reg_sel));

   a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq);

   a_r6_irq_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_irq);

   a_r6_eight_rises: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> (rise_cnt == RW'(DATA_W)));

   a_r7_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_out);

   a_r5_rxonly_so_held: assert property (@(posedge clk) disable iff (!rst_n)
      mode_bits[0] |=> $stable(so));

   a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mode_bits));

endmodule

bind sync_shift_port sync_shift_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .busy      (busy),
   .done_irq  (done_irq),
   .so        (so),
   .sck_out   (sck_out),
   .mode_bits (mode_bits),
   .rise_evt  (rise_evt)
);

// File: tb/sync_shift_port_bench.sv
`timescale 1ns/1ps
module sync_shift_port_bench;
   localparam int HALF = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       sck_in = 1'b1;
   logic       sck_out;
   logic       sck_drive;
   logic       tmr_strobe = 1'b0;
   logic       si = 1'b1;
   logic       so;
   logic       busy;
   logic       done_irq;

   int n_run = 0;
   int n_fail = 0;
   int irq_cnt = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   sync_shift_port #(.DATA_W(8), .HALF_DIV(HALF), .SYNC_STAGES(2)) u_sync_shift_port (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in),
      .sck_out(sck_out), .sck_drive(sck_drive), .tmr_strobe(tmr_strobe),
      .si(si), .so(so), .busy(busy), .done_irq(done_irq)
   );

   always @(negedge clk) if (done_irq) irq_cnt++;

   // vectors: {mode[3:0], tx[7:0], si_word[7:0]}
   // mode: bit0 receive-only, bit1 lsb-first, [3:2] 00 int, 01 ext, 1x timer
   localparam logic [19:0] VEC [8] = '{
      {4'b0000, 8'hA5, 8'h3C},
      {4'b0010, 8'h81, 8'hC3},
      {4'b0100, 8'h5A, 8'h96},
      {4'b0110, 8'h01, 8'h7E},
      {4'b1000, 8'hFF, 8'h00},
      {4'b1010, 8'h00, 8'hFF},
      {4'b0001, 8'hF0, 8'h55},
      {4'b0111, 8'h33, 8'hA9}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] v);
      reg_sel = sel;
      #1 v = reg_rdata;
   endtask

   function automatic int bidx(input logic lsb, input int i);
      return lsb ? i : 7 - i;
   endfunction

   logic [7:0] rec;
   int         falls;
   bit         so_moved;
   bit         extra_toggle;

   task automatic xfer(input logic [3:0] md, input logic [7:0] tx, input logic [7:0] sw);
      logic lsb, ext, tmr, prev, so_before;
      int rises, n;
      lsb = md[1]; ext = (md[3:2] == 2'b01); tmr = md[3];
      wr(1'b0, {4'h0, md});
      so_before = so;
      si = sw[bidx(lsb, 0)];
      wr(1'b1, tx);
      rec = '0; falls = 0; so_moved = 0; extra_toggle = 0;
      if (ext) begin
         for (int i = 0; i < 8; i++) begin
            si = sw[bidx(lsb, i)];
            sck_in = 1'b0;
            repeat (4) @(negedge clk);
            rec[bidx(lsb, i)] = so;
            if (so !== so_before) so_moved = 1;
            if (sck_out !== 1'b1) extra_toggle = 1;
            falls++;
            sck_in = 1'b1;
            repeat (4) @(negedge clk);
         end
      end else begin
         prev = 1'b1; rises = 0; n = 0;
         while (rises < 8 && n < 3000) begin
            if (tmr) tmr_strobe = (n % 3 == 0);
            n++;
            @(negedge clk);
            if (so !== so_before) so_moved = 1;
            if (prev && !sck_out) begin
               if (falls < 8) rec[bidx(lsb, falls)] = so;
               falls++;
            end
            if (!prev && sck_out) begin
               rises++;
               if (rises < 8) si = sw[bidx(lsb, rises)];
            end
            prev = sck_out;
         end
         tmr_strobe = 1'b0;
      end
      repeat (20) begin
         @(negedge clk);
         if (sck_out !== 1'b1) extra_toggle = 1;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog R6 actual=hung expected=complete");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int base, cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 done_irq", done_irq, 0);
      chk("R1 so", so, 1);
      chk("R1 sck_out", sck_out, 1);
      rd(1'b0, v); chk("R1 R11 mode read", v, 8'h00);
      rd(1'b1, v); chk("R1 R11 buffer read", v, 8'h00);

      // vector table
      for (int k = 0; k < 8; k++) begin
         logic [3:0] md;
         logic [7:0] tx, sw;
         md = VEC[k][19:16]; tx = VEC[k][15:8]; sw = VEC[k][7:0];
         base = irq_cnt;
         xfer(md, tx, sw);
         rd(1'b1, v);
         chk(md[0] ? "R5 rx-only buffer" : "R4 received byte", v, sw);
         if (md[0]) chk("R5 so held", so_moved, 0);
         else       chk("R3 transmitted byte", rec, tx);
         chk("R6 one done pulse", irq_cnt - base, 1);
         chk("R6 busy cleared", busy, 0);
         chk("R7 R8 R9 falls and idle high", {falls[7:0], 7'b0, extra_toggle}, {8'd8, 8'd0});
         chk("R7 R8 sck_drive", sck_drive, (md[3:2] == 2'b01) ? 1'b0 : 1'b1);
         rd(1'b0, v); chk("R11 mode readback", v, {4'h0, md});
      end

      // R7 transfer length with internal clock
      wr(1'b0, 8'h00);
      si = 1'b0;
      wr(1'b1, 8'h00);
      cyc = 0;
      while (busy && cyc < 1000) begin @(negedge clk); cyc++; end
      chk("R7 busy length", cyc, 16 * HALF);

      // R2 R10 writes during a transfer are refused
      wr(1'b0, 8'h00);
      si = 1'b0;
      wr(1'b1, 8'h00);
      repeat (5) @(negedge clk);
      wr(1'b1, 8'hFF);
      rd(1'b1, v); chk("R2 buffer write while busy", v, 8'h00);
      wr(1'b0, 8'h0F);
      rd(1'b0, v); chk("R10 mode write while busy", v, 8'h00);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      rd(1'b1, v); chk("R2 buffer after refused write", v, 8'h00);
      rd(1'b0, v); chk("R10 mode after refused write", v, 8'h00);
      wr(1'b0, 8'h0A);
      rd(1'b0, v); chk("R10 mode write when idle", v, 8'h0A);

      // R9 strobes while idle
      wr(1'b0, 8'h08);
      si = 1'b1;
      base = irq_cnt;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); tmr_strobe = 1'b1;
         @(negedge clk); tmr_strobe = 1'b0;
         if (sck_out !== 1'b1) extra_toggle = 1;
      end
      chk("R9 idle strobes busy", busy, 0);
      chk("R9 idle strobes sck_out", sck_out, 1);
      rd(1'b1, v); chk("R9 idle strobes buffer", v, 8'h00);

      // R8 external edges while idle
      wr(1'b0, 8'h04);
      for (int i = 0; i < 6; i++) begin
         sck_in = 1'b0; repeat (4) @(negedge clk);
         sck_in = 1'b1; repeat (4) @(negedge clk);
      end
      chk("R8 idle edges busy", busy, 0);
      chk("R8 idle edges irq", irq_cnt - base, 0);
      rd(1'b1, v); chk("R8 idle edges buffer", v, 8'h00);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule